// File: doc/BRIEF.md
# Serial Character Transmitter

This block turns characters into serial frames on a single transmit line. A character enters through a one-entry holding stage. When the shift stage is idle, or is in the last timing step of its final stop bit, the character moves across. The shift stage then sends a low start bit, the data bits, an optional parity bit and one, one and a half or two high stop bits. Between frames and while the transmitter is disabled, the line sits high.

Configuration inputs set the frame format. The data width is five to eight bits, or nine through an override. Parity is one of five kinds, bit order is selectable, and so are the stop length and a synchronous/asynchronous mode. The configuration is captured when a character enters the shift stage. All timing comes from a single enable pulse. In asynchronous mode it is a 16x oversampling tick, and each bit lasts `OVS` ticks. In synchronous mode each tick stands for one falling edge of the serial clock, and each bit lasts one tick.

Two flags report progress. `rdy` means the holding stage can take a character. `empty` means every accepted character has been sent in full. A write made while `rdy` is low is discarded.

Top module: `sertx_core`

## Requirements
- R1: While enabled and idle, `txd` is high. Each frame is a 0 start bit, then the data bits, then the parity bit if one is selected, then stop bits at 1.
- R2: `cfg_nine`=1 gives 9 data bits. Otherwise `cfg_len` 0,1,2,3 gives 5,6,7,8 data bits, taken from the low bits of `wr_data`.
- R3: `cfg_par` selects the parity bit. 0 is even (the data ones plus the parity bit count even), 1 is odd, 2 is always 0, 3 is always 1, and 4 to 7 send no parity bit.
- R4: With `cfg_msb_first`=1, the highest data bit is sent first. With it at 0, bit 0 is sent first.
- R5: `cfg_stop` selects the stop length. 0 gives one stop bit and 2 or 3 give two. 1 gives one and a half stop bits in asynchronous mode, where the last stop half lasts `OVS`/2 ticks. In synchronous mode, 1 gives one stop bit.
- R6: In asynchronous mode (`cfg_sync`=0) each bit lasts `OVS` ticks. In synchronous mode each bit lasts one tick. `txd` changes only in the cycle after a `tick` pulse.
- R7: A held character enters the shift stage on a tick cycle where the shift stage is idle or ending its final stop bit. That start bit appears on `txd` in the next cycle, `rdy` rises in that same cycle, and back-to-back frames have no idle gap.
- R8: `empty` is high only when the block is enabled, the holding stage is empty and no frame is in progress. `rdy` is high exactly when the block is enabled and the holding stage is empty.
- R9: While `enable` is low, `rdy` and `empty` are low and `txd` is high. A frame in progress and a held character are both discarded.
- R10: A write made while `rdy` is low has no effect, and that character is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Transmitter enable |
| tick | input | 1 | Baud enable: a 16x oversampling tick in asynchronous mode, a serial clock falling edge in synchronous mode |
| cfg_len | input | 2 | Data length code, 0..3 for 5..8 bits |
| cfg_nine | input | 1 | Forces 9 data bits |
| cfg_par | input | 3 | Parity kind |
| cfg_msb_first | input | 1 | Bit order |
| cfg_stop | input | 2 | Stop length code |
| cfg_sync | input | 1 | 1 selects synchronous mode |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 9 | Character to write |
| txd | output | 1 | Serial output |
| rdy | output | 1 | Holding stage empty |
| empty | output | 1 | All accepted characters fully sent |

## Verification
The hardest case to reach is a character sitting in the holding stage when the shift stage reaches the final tick of a stop bit. That handoff must start the next frame with no gap. A write strobe arriving in the same window must also be dropped. The bench reaches this case by writing a second character as soon as the first one leaves the holding stage. It then keeps strobing writes while `rdy` is low, under both a sparse tick pattern and a tick on every cycle. A behavioural frame queue is compared with `txd` and both flags on every cycle.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_MAX  = 9;
    localparam int FRAME_MAX = DATA_MAX + 4;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [2:0] {
        PAR_EVEN = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_ZERO = 3'd2,
        PAR_ONE  = 3'd3,
        PAR_NONE = 3'd4
    } par_kind_e;

    typedef struct packed {
        logic [1:0] len;
        logic       nine;
        logic [2:0] par;
        logic       msb_first;
        logic [1:0] stop;
        logic       sync;
    } tx_cfg_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [CNT_W-1:0]     nbits;
        logic                 half_stop;
        logic                 sync;
    } frame_t;

    function automatic par_kind_e par_kind(logic [2:0] code);
        case (code)
            3'd0:    return PAR_EVEN;
            3'd1:    return PAR_ODD;
            3'd2:    return PAR_ZERO;
            3'd3:    return PAR_ONE;
            default: return PAR_NONE;
        endcase
    endfunction

    function automatic int data_width(tx_cfg_t c);
        return c.nine ? DATA_MAX : 5 + int'(c.len);
    endfunction

    function automatic frame_t build_frame(tx_cfg_t c, logic [DATA_MAX-1:0] d);
        frame_t              f;
        int                  w;
        int                  nstop;
        logic                has_par;
        logic                p;
        logic [DATA_MAX-1:0] mask;
        par_kind_e           k;
        w       = data_width(c);
        k       = par_kind(c.par);
        mask    = {DATA_MAX{1'b1}} >> (DATA_MAX - w);
        has_par = (k != PAR_NONE);
        case (k)
            PAR_EVEN: p = ^(d & mask);
            PAR_ODD:  p = ~^(d & mask);
            PAR_ONE:  p = 1'b1;
            default:  p = 1'b0;
        endcase
        f.bits    = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < w) f.bits[1+i] = c.msb_first ? d[w-1-i] : d[i];
        end
        if (has_par) f.bits[1+w] = p;
        if (c.stop[1])                        nstop = 2;
        else if (c.stop[0] && !c.sync)        nstop = 2;
        else                                  nstop = 1;
        f.nbits     = CNT_W'(1 + w + int'(has_par) + nstop);
        f.half_stop = (c.stop == 2'd1) && !c.sync;
        f.sync      = c.sync;
        return f;
    endfunction

endpackage

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  tx_cfg_t               cfg,
    input  logic [DATA_MAX-1:0]   data,
    output frame_t                frame
);
    always_comb frame = build_frame(cfg, data);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                take,
    output logic                full,
    output logic [DATA_MAX-1:0] data
);
    logic accept;
    assign accept = wr_en && enable && !full;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   tick,
    input  logic   load,
    input  frame_t frame,
    output logic   txd,
    output logic   busy,
    output logic   can_load
);
    localparam int SUB_W = $clog2(OVS);
    localparam int HALF  = OVS / 2;

    logic [FRAME_MAX-1:0] shreg;
    logic [CNT_W-1:0]     left;
    logic [SUB_W-1:0]     sub;
    logic [SUB_W-1:0]     lim;
    logic                 sync_q;
    logic                 half_q;
    logic                 last;
    logic                 bit_end;

    assign last     = (left == '0);
    assign lim      = sync_q ? '0 : ((last && half_q) ? SUB_W'(HALF - 1) : SUB_W'(OVS - 1));
    assign bit_end  = busy && tick && (sub == lim);
    assign can_load = !busy || (bit_end && last);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            busy   <= 1'b0;
            txd    <= 1'b1;
            shreg  <= '1;
            left   <= '0;
            sub    <= '0;
            sync_q <= 1'b0;
            half_q <= 1'b0;
        end else if (load) begin
            busy   <= 1'b1;
            txd    <= frame.bits[0];
            shreg  <= frame.bits >> 1;
            left   <= frame.nbits - CNT_W'(1);
            sub    <= '0;
            sync_q <= frame.sync;
            half_q <= frame.half_stop;
        end else if (busy && tick) begin
            if (bit_end) begin
                sub <= '0;
                if (last) begin
                    busy <= 1'b0;
                    txd  <= 1'b1;
                end else begin
                    txd   <= shreg[0];
                    shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
                    left  <= left - CNT_W'(1);
                end
            end else begin
                sub <= sub + SUB_W'(1);
            end
        end
    end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_nine,
    input  logic [2:0] cfg_par,
    input  logic       cfg_msb_first,
    input  logic [1:0] cfg_stop,
    input  logic       cfg_sync,
    input  logic       wr_en,
    input  logic [8:0] wr_data,
    output logic       txd,
    output logic       rdy,
    output logic       empty
);
    tx_cfg_t             cfg;
    frame_t              frame;
    logic                hold_full;
    logic [DATA_MAX-1:0] hold_data;
    logic                busy;
    logic                can_load;
    logic                load;

    assign cfg   = '{len: cfg_len, nine: cfg_nine, par: cfg_par, msb_first: cfg_msb_first,
                     stop: cfg_stop, sync: cfg_sync};
    assign load  = enable && tick && hold_full && can_load;
    assign rdy   = enable && !hold_full;
    assign empty = enable && !hold_full && !busy;

    sertx_hold u_hold (
        .clk(clk), .rst(rst), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
        .take(load), .full(hold_full), .data(hold_data)
    );

    sertx_framer u_framer (.cfg(cfg), .data(hold_data), .frame(frame));

    sertx_shift #(.OVS(OVS)) u_shift (
        .clk(clk), .rst(rst), .enable(enable), .tick(tick), .load(load),
        .frame(frame), .txd(txd), .busy(busy), .can_load(can_load)
    );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic tick,
    input logic wr_en,
    input logic txd,
    input logic rdy,
    input logic empty
);
    // R9: disabled forces the line high and the flags low
    p_off_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (txd && !rdy && !empty) || enable);

    // R1: nothing is in flight while the block reports empty, so the line idles high
    p_empty_high_r1: assert property (@(posedge clk) disable iff (rst)
        empty |-> txd);

    // R8: empty implies the holding stage is free
    p_empty_rdy_r8: assert property (@(posedge clk) disable iff (rst)
        empty |-> rdy);

    // R7: ready rising while enabled means a handoff, which starts with a low start bit
    p_handoff_start_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(rdy) && $past(enable)) |-> !txd);

    // R6: the line moves only after a tick
    p_tick_only_r6: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !$past(tick)) |-> $stable(txd));

    // R10: a write while not ready cannot make ready rise without a tick
    p_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (enable && !rdy && !tick && wr_en) |=> (!rdy || !enable));
endmodule

bind sertx_core sertx_checker i_chk (.*);

// File: tb/test_sertx_core.sv
module test_sertx_core;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_nine = 1'b0;
    logic [2:0] cfg_par = 3'd4;
    logic       cfg_msb_first = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic       cfg_sync = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       txd, rdy, empty;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    tick_mode = 0;
    string cur_req = "R9";

    // reference model state
    bit        m_full = 0;
    bit [8:0]  m_data = 0;
    bit        m_busy = 0;
    bit        m_txd = 1;
    int        m_cnt = 0;
    bit        mq[$];
    int        md[$];

    sertx_core #(.OVS(OVS)) i_sertx_core (
        .clk(clk), .rst(rst), .enable(enable), .tick(tick),
        .cfg_len(cfg_len), .cfg_nine(cfg_nine), .cfg_par(cfg_par),
        .cfg_msb_first(cfg_msb_first), .cfg_stop(cfg_stop), .cfg_sync(cfg_sync),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .rdy(rdy), .empty(empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic m_build();
        int w;
        int ones;
        int dur;
        bit b;
        w    = cfg_nine ? 9 : 5 + int'(cfg_len);
        dur  = cfg_sync ? 1 : OVS;
        ones = 0;
        mq.delete();
        md.delete();
        mq.push_back(1'b0); md.push_back(dur);
        for (int i = 0; i < w; i++) begin
            b = cfg_msb_first ? m_data[w-1-i] : m_data[i];
            mq.push_back(b); md.push_back(dur);
        end
        for (int i = 0; i < w; i++) if (m_data[i]) ones++;
        if (cfg_par < 3'd4) begin
            case (cfg_par)
                3'd0: b = (ones % 2) == 1;
                3'd1: b = (ones % 2) == 0;
                3'd2: b = 1'b0;
                default: b = 1'b1;
            endcase
            mq.push_back(b); md.push_back(dur);
        end
        mq.push_back(1'b1); md.push_back(dur);
        if (cfg_stop >= 2'd2) begin
            mq.push_back(1'b1); md.push_back(dur);
        end else if (cfg_stop == 2'd1 && !cfg_sync) begin
            mq.push_back(1'b1); md.push_back(OVS / 2);
        end
    endtask

    always @(posedge clk) begin
        bit was_busy, finishing, rdy_pre;
        if (rst || !enable) begin
            m_full = 0; m_busy = 0; m_txd = 1; m_cnt = 0;
            mq.delete(); md.delete();
        end else begin
            was_busy  = m_busy;
            rdy_pre   = !m_full;
            finishing = m_busy && tick && (m_cnt + 1 == md[0]) && (mq.size() == 1);
            if (m_busy && tick) begin
                m_cnt++;
                if (m_cnt == md[0]) begin
                    void'(mq.pop_front()); void'(md.pop_front());
                    m_cnt = 0;
                    if (mq.size() == 0) begin m_busy = 0; m_txd = 1; end
                    else m_txd = mq[0];
                end
            end
            if (tick && m_full && (!was_busy || finishing)) begin
                m_build();
                m_full = 0; m_busy = 1; m_cnt = 0; m_txd = mq[0];
            end else if (wr_en && rdy_pre) begin
                m_full = 1; m_data = wr_data;
            end
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, a quarter period after the falling edge
    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            cyc++;
            if (!rst) begin
                check(cur_req, "txd", txd, m_txd);
                check(cur_req, "rdy", rdy, enable && !m_full);
                check(cur_req, "empty", empty, enable && !m_full && !m_busy);
            end
            if (cyc >= WATCHDOG) begin
                n_bad++;
                $display("FAIL %s watchdog expired", cur_req);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    // tick pattern: mode 0 every other cycle, mode 1 every cycle, mode 2 irregular
    initial begin
        int k;
        k = 0;
        forever begin
            @(negedge clk);
            k++;
            case (tick_mode)
                0:       tick = (k % 2) == 0;
                1:       tick = 1'b1;
                default: tick = (k % 3) != 1;
            endcase
        end
    end

    task automatic set_cfg(int len, bit nine, int par, bit msb, int stop, bit sync);
        @(negedge clk);
        cfg_len = 2'(len); cfg_nine = nine; cfg_par = 3'(par);
        cfg_msb_first = msb; cfg_stop = 2'(stop); cfg_sync = sync;
    endtask

    task automatic send(logic [8:0] d);
        @(negedge clk);
        while (!rdy) @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic poke(logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (!empty) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #(CLK_PERIOD/4);
        check("R9", "reset txd", txd, 1'b1);
        check("R9", "reset rdy", rdy, 1'b0);
        check("R9", "reset empty", empty, 1'b0);

        @(negedge clk);
        enable = 1'b1;
        cur_req = "R8";
        #(CLK_PERIOD/4);
        check("R8", "enabled rdy", rdy, 1'b1);
        check("R8", "enabled empty", empty, 1'b1);

        cur_req = "R1";
        set_cfg(3, 0, 4, 0, 0, 0);
        send(9'h0A5);
        send(9'h03C);
        cur_req = "R7";
        send(9'h0F0);
        drain();

        cur_req = "R2";
        for (int l = 0; l < 4; l++) begin
            set_cfg(l, 0, 0, 0, 0, 0);
            send(9'h16B);
            drain();
        end
        set_cfg(1, 1, 4, 0, 0, 0);
        send(9'h1C3);
        drain();

        cur_req = "R3";
        for (int p = 0; p < 6; p++) begin
            set_cfg(3, 0, p, 0, 0, 0);
            send(9'h0B7);
            send(9'h001);
            drain();
        end

        cur_req = "R4";
        set_cfg(2, 0, 1, 1, 0, 0);
        send(9'h041);
        set_cfg(3, 1, 0, 1, 2, 0);
        drain();
        send(9'h101);
        drain();

        cur_req = "R5";
        for (int s = 0; s < 4; s++) begin
            set_cfg(3, 0, 0, 0, s, 0);
            send(9'h055);
            send(9'h0AA);
            drain();
        end

        cur_req = "R6";
        tick_mode = 1;
        for (int s = 0; s < 3; s++) begin
            set_cfg(3, 0, 1, 0, s, 1);
            send(9'h0C6);
            send(9'h039);
            drain();
        end
        tick_mode = 2;
        set_cfg(0, 0, 0, 1, 1, 0);
        send(9'h013);
        send(9'h00C);
        drain();
        tick_mode = 0;

        cur_req = "R10";
        set_cfg(3, 0, 4, 0, 0, 0);
        send(9'h011);
        send(9'h022);
        poke(9'h0FF);
        #(CLK_PERIOD/4);
        check("R10", "rdy after dropped write", rdy, 1'b0);
        poke(9'h0EE);
        tick_mode = 1;
        set_cfg(3, 0, 4, 0, 0, 1);
        send(9'h033);
        send(9'h044);
        for (int i = 0; i < 12; i++) poke(9'(9'h080 + i));
        drain();
        tick_mode = 0;

        cur_req = "R9";
        set_cfg(3, 0, 0, 0, 2, 0);
        send(9'h077);
        send(9'h088);
        repeat (60) @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        #(CLK_PERIOD/4);
        check("R9", "disabled txd", txd, 1'b1);
        check("R9", "disabled rdy", rdy, 1'b0);
        check("R9", "disabled empty", empty, 1'b0);
        poke(9'h099);
        @(negedge clk);
        enable = 1'b1;
        #(CLK_PERIOD/4);
        check("R9", "re-enabled empty", empty, 1'b1);
        send(9'h05A);
        drain();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule